// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a sticky record of why the chip last went through reset. Six cause flags are tracked: power (power-on or an enabled low-voltage detection), the external reset pin, a main-clock stop, a sub-clock stop, a firmware-requested reset and the watchdog. Single-cycle event inputs and a few qualifying inputs decide when a clock-stop or watchdog condition counts as a cause. Each flag is set by its own condition.

The flags live in a register domain that only the power reset touches. Every other reset leaves them alone. Firmware reads them over a simple read-only register bus. A read of the full status word has no side effects. A read of the cause byte returns the flags and clears them in the same access. Whenever a non-power cause fires, the block also raises a system reset request for a fixed number of cycles.

Top module: `rst_cause_reg`

## Requirements
- R1: A read at `BASE_ADDR` (default 12'h40A) returns, in the next cycle on `bus_rdata`, the flags at bit 8 power, bit 9 external, bit 10 main-clock-stop, bit 11 sub-clock-stop, bit 12 software and bit 13 watchdog. Bits 0 to 7 and 14 to 15 are zero, and this read leaves the flags unchanged.
- R2: A power reset sets the power and external flags and keeps the other four at their prior value. A power reset is `por_evt`, or `lvd_evt` while `lvd_en` is 1. `lvd_evt` with `lvd_en` at 0 changes nothing.
- R3: `ext_rst_n` at 0 during a clock edge sets the external flag.
- R4: `main_clk_lost` sets the main-clock-stop flag when any of `sys1_src`, `sys2_src` or `wdt_src` selects main (2'b00) or PLL (2'b10). The input is ignored when none of them does.
- R5: `sub_clk_lost` sets the sub-clock-stop flag when any of the three selectors is sub (2'b11). The input is ignored otherwise.
- R6: `clk_en_off[0]` (RC oscillator enable written 0) while `csd_rst_en` is 1 sets both clock-stop flags. With `csd_rst_en` at 0 it sets neither.
- R7: `sw_rst_wr` sets the software flag.
- R8: The watchdog flag sets on any of these conditions:
  - `wdt_expired`;
  - `wdt_bad_key`;
  - the `clk_en_off` bit for the watchdog's clock being 1, where RC (2'b01) maps to bit 0, main or PLL to bit 1, and sub to bit 2;
  - `rc_freq_wr` while `wdt_src` is 2'b01 (with any other source it is ignored);
  - `stop_req` while `rst_on_stop` is 1.
- R9: A read at `BASE_ADDR+1` returns the flags in bits 5:0 (same order as R1, other bits zero) one cycle later, and clears every flag.
- R10: When a clearing read and a set condition fall on the same edge, the read returns the old flags and the newly set flag stays 1.
- R11: Any non-power set condition drives `sys_rst_req` high from the following edge for exactly 16 cycles. A new condition restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_evt | input | 1 | Power-on reset, active high, synchronous |
| lvd_evt | input | 1 | Low-voltage detection |
| lvd_en | input | 1 | Low-voltage reset enable |
| ext_rst_n | input | 1 | External reset pin, active low |
| main_clk_lost | input | 1 | Main clock missing |
| sub_clk_lost | input | 1 | Sub clock missing |
| sys1_src | input | 2 | System clock 1 source: 00 main, 01 RC, 10 PLL, 11 sub |
| sys2_src | input | 2 | System clock 2 source, same coding |
| wdt_src | input | 2 | Watchdog clock source, same coding |
| clk_en_off | input | 3 | Enable written 0: bit 0 RC, bit 1 main, bit 2 sub |
| csd_rst_en | input | 1 | Clock-stop-detection reset enabled |
| sw_rst_wr | input | 1 | Software reset bit written 1 |
| wdt_expired | input | 1 | Watchdog not cleared in time |
| wdt_bad_key | input | 1 | Illegal watchdog clear pattern |
| rc_freq_wr | input | 1 | RC frequency changed |
| stop_req | input | 1 | Stop mode requested |
| rst_on_stop | input | 1 | Reset on stop request enabled |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Read address |
| bus_rdata | output | 16 | Registered read data |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
Every flag and the read data pass through one register, so a condition present at edge N is visible to a read whose strobe is sampled at edge N+1, and that read's data is valid just after edge N+1. The bench drives all inputs at falling edges. It samples one time unit after the rising edge that captured the read, so each check sees exactly the edge it targets.

The reset request rises on the edge that captures the trigger. It is counted at falling edges, sixteen in a row, starting from the falling edge right after that capture.

The same-edge case of R10 is checked on both sides: the returned byte must show only the old flags, and a later word read must show the new one.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NUM_CAUSE = 6;
  localparam int CI_PWR  = 0;
  localparam int CI_EXT  = 1;
  localparam int CI_MCS  = 2;
  localparam int CI_SCS  = 3;
  localparam int CI_SW   = 4;
  localparam int CI_WDT  = 5;
  localparam logic [1:0] SRC_MAIN = 2'b00;
  localparam logic [1:0] SRC_RC   = 2'b01;
  localparam logic [1:0] SRC_PLL  = 2'b10;
  localparam logic [1:0] SRC_SUB  = 2'b11;
endpackage

// File: rtl/rcc_cause_decode.sv
module rcc_cause_decode
  import rcc_pkg::*;
(
  input  logic                 ext_rst_n,
  input  logic                 main_clk_lost,
  input  logic                 sub_clk_lost,
  input  logic [1:0]           sys1_src,
  input  logic [1:0]           sys2_src,
  input  logic [1:0]           wdt_src,
  input  logic [2:0]           clk_en_off,
  input  logic                 csd_rst_en,
  input  logic                 sw_rst_wr,
  input  logic                 wdt_expired,
  input  logic                 wdt_bad_key,
  input  logic                 rc_freq_wr,
  input  logic                 stop_req,
  input  logic                 rst_on_stop,
  output logic [NUM_CAUSE-1:0] set_vec
);
  logic main_used, sub_used, rc_off_csd, wdt_clk_off;
  logic [1:0] wdt_clk_idx;

  always_comb begin
    main_used = (sys1_src == SRC_MAIN) || (sys1_src == SRC_PLL) ||
                (sys2_src == SRC_MAIN) || (sys2_src == SRC_PLL) ||
                (wdt_src  == SRC_MAIN) || (wdt_src  == SRC_PLL);
    sub_used  = (sys1_src == SRC_SUB) || (sys2_src == SRC_SUB) ||
                (wdt_src == SRC_SUB);
    rc_off_csd = clk_en_off[0] & csd_rst_en;
    case (wdt_src)
      SRC_RC:  wdt_clk_idx = 2'd0;
      SRC_SUB: wdt_clk_idx = 2'd2;
      default: wdt_clk_idx = 2'd1;
    endcase
    wdt_clk_off = clk_en_off[wdt_clk_idx];
  end

  always_comb begin
    set_vec          = '0;
    set_vec[CI_EXT]  = ~ext_rst_n;
    set_vec[CI_MCS]  = (main_clk_lost & main_used) | rc_off_csd;
    set_vec[CI_SCS]  = (sub_clk_lost & sub_used) | rc_off_csd;
    set_vec[CI_SW]   = sw_rst_wr;
    set_vec[CI_WDT]  = wdt_expired | wdt_bad_key | wdt_clk_off |
                       (rc_freq_wr & (wdt_src == SRC_RC)) |
                       (stop_req & rst_on_stop);
  end
endmodule

// File: rtl/rcc_flag_bank.sv
module rcc_flag_bank
  import rcc_pkg::*;
(
  input  logic                 clk,
  input  logic                 pwr_rst,
  input  logic [NUM_CAUSE-1:0] set_vec,
  input  logic                 clr,
  output logic [NUM_CAUSE-1:0] flags
);
  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (pwr_rst) begin
        if (i == CI_PWR || i == CI_EXT) flags[i] <= 1'b1;
      end else begin
        flags[i] <= (flags[i] & ~clr) | set_vec[i];
      end
    end
  end

  // R7, R10: a set condition leaves its flag at 1, even under a clearing read
  a_r10_set_wins: assert property (@(posedge clk) disable iff (pwr_rst)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
  // R9: a clearing read with no set condition empties the flags
  a_r9_clear: assert property (@(posedge clk) disable iff (pwr_rst)
    (clr && !(|set_vec)) |=> (flags == '0));
  // R1: without a clearing read or a set condition the flags hold
  a_r1_hold: assert property (@(posedge clk) disable iff (pwr_rst)
    (!clr && !(|set_vec)) |=> $stable(flags));
endmodule

// File: rtl/rcc_rst_pulse.sv
module rcc_rst_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic pwr_rst,
  input  logic trig,
  output logic req
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (trig) begin
      cnt <= LOAD;
      req <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      req <= (cnt > CW'(1));
    end
  end

  // R11: request rises on the edge that captures a trigger
  a_r11_start: assert property (@(posedge clk) disable iff (pwr_rst)
    trig |=> req);
  // R11: request ends once the count is spent
  a_r11_end: assert property (@(posedge clk) disable iff (pwr_rst)
    (!trig && cnt <= CW'(1)) |=> !req);
  // R11: no request appears without a trigger
  a_r11_idle: assert property (@(posedge clk) disable iff (pwr_rst)
    (!req && !trig) |=> !req);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcc_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] BASE_ADDR = 12'h40A,
  parameter int          PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              por_evt,
  input  logic              lvd_evt,
  input  logic              lvd_en,
  input  logic              ext_rst_n,
  input  logic              main_clk_lost,
  input  logic              sub_clk_lost,
  input  logic [1:0]        sys1_src,
  input  logic [1:0]        sys2_src,
  input  logic [1:0]        wdt_src,
  input  logic [2:0]        clk_en_off,
  input  logic              csd_rst_en,
  input  logic              sw_rst_wr,
  input  logic              wdt_expired,
  input  logic              wdt_bad_key,
  input  logic              rc_freq_wr,
  input  logic              stop_req,
  input  logic              rst_on_stop,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_rdata,
  output logic              sys_rst_req
);
  localparam logic [ADDR_W-1:0] WORD_ADR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] BYTE_ADR = ADDR_W'(BASE_ADDR) + ADDR_W'(1);

  logic                 pwr_rst;
  logic [NUM_CAUSE-1:0] set_vec, flags;
  logic                 rd_word, rd_byte;

  assign pwr_rst = por_evt | (lvd_evt & lvd_en);
  assign rd_word = bus_rd && (bus_addr == WORD_ADR);
  assign rd_byte = bus_rd && (bus_addr == BYTE_ADR);

  rcc_cause_decode u_dec (
    .ext_rst_n(ext_rst_n), .main_clk_lost(main_clk_lost),
    .sub_clk_lost(sub_clk_lost), .sys1_src(sys1_src), .sys2_src(sys2_src),
    .wdt_src(wdt_src), .clk_en_off(clk_en_off), .csd_rst_en(csd_rst_en),
    .sw_rst_wr(sw_rst_wr), .wdt_expired(wdt_expired),
    .wdt_bad_key(wdt_bad_key), .rc_freq_wr(rc_freq_wr),
    .stop_req(stop_req), .rst_on_stop(rst_on_stop), .set_vec(set_vec)
  );

  rcc_flag_bank u_flags (
    .clk(clk), .pwr_rst(pwr_rst), .set_vec(set_vec),
    .clr(rd_byte), .flags(flags)
  );

  rcc_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .pwr_rst(pwr_rst), .trig(|set_vec), .req(sys_rst_req)
  );

  always_ff @(posedge clk) begin
    if (pwr_rst)      bus_rdata <= '0;
    else if (rd_word) bus_rdata <= {2'b00, flags, 8'h00};
    else if (rd_byte) bus_rdata <= {10'h000, flags};
    else              bus_rdata <= '0;
  end

  // R1, R9: unused positions of the read data stay zero
  a_r1_pad_zero: assert property (@(posedge clk) disable iff (pwr_rst)
    (bus_rdata[15:14] == 2'b00) &&
    ((bus_rdata[15:8] == 8'h00) || (bus_rdata[7:0] == 8'h00)));
  // R9: a clearing read returns the flags held before the edge
  a_r9_byte_data: assert property (@(posedge clk) disable iff (pwr_rst)
    rd_byte |=> (bus_rdata[5:0] == $past(flags)));
endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] WADR = 12'h40A;
  localparam logic [11:0] BADR = 12'h40B;
  localparam logic [15:0] B_PWR = 16'h0100, B_EXT = 16'h0200,
    B_MCS = 16'h0400, B_SCS = 16'h0800, B_SW = 16'h1000, B_WDT = 16'h2000;

  logic clk = 1'b0;
  logic por_evt = 1'b1, lvd_evt = 1'b0, lvd_en = 1'b0, ext_rst_n = 1'b1;
  logic main_clk_lost = 1'b0, sub_clk_lost = 1'b0;
  logic [1:0] sys1_src = 2'b01, sys2_src = 2'b01, wdt_src = 2'b01;
  logic [2:0] clk_en_off = 3'b000;
  logic csd_rst_en = 1'b0, sw_rst_wr = 1'b0, wdt_expired = 1'b0;
  logic wdt_bad_key = 1'b0, rc_freq_wr = 1'b0, stop_req = 1'b0;
  logic rst_on_stop = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_rdata;
  logic sys_rst_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg dut_i (
    .clk(clk), .por_evt(por_evt), .lvd_evt(lvd_evt), .lvd_en(lvd_en),
    .ext_rst_n(ext_rst_n), .main_clk_lost(main_clk_lost),
    .sub_clk_lost(sub_clk_lost), .sys1_src(sys1_src), .sys2_src(sys2_src),
    .wdt_src(wdt_src), .clk_en_off(clk_en_off), .csd_rst_en(csd_rst_en),
    .sw_rst_wr(sw_rst_wr), .wdt_expired(wdt_expired),
    .wdt_bad_key(wdt_bad_key), .rc_freq_wr(rc_freq_wr),
    .stop_req(stop_req), .rst_on_stop(rst_on_stop), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1; d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    bus_read(BADR, d);
  endtask

  task automatic expect_word(input string tag, input logic [15:0] exp);
    logic [15:0] d;
    bus_read(WADR, d);
    check(tag, d, exp);
  endtask

  task automatic pulse_gap();
    @(negedge clk);
    ext_rst_n = 1'b1; main_clk_lost = 1'b0; sub_clk_lost = 1'b0;
    clk_en_off = 3'b000; sw_rst_wr = 1'b0; wdt_expired = 1'b0;
    wdt_bad_key = 1'b0; rc_freq_wr = 1'b0; stop_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); por_evt = 1'b0;
    check("R11 no request after power reset", {15'd0, sys_rst_req}, 16'd0);
    bus_read(WADR, d);
    check("R2 power reset marks power+ext", d & (B_PWR | B_EXT), B_PWR | B_EXT);
    check("R1 padding bits zero", d & 16'hC0FF, 16'h0000);
    bus_read(WADR, d);
    check("R1 word read does not clear", d & (B_PWR | B_EXT), B_PWR | B_EXT);
    bus_read(BADR, d);
    check("R9 byte read data", d & 16'hFFC3, 16'h0003);
    expect_word("R9 flags cleared", 16'h0000);
  endtask

  task automatic t_ext();
    @(negedge clk); ext_rst_n = 1'b0; pulse_gap();
    expect_word("R3 ext pin", B_EXT); clear_all();
  endtask

  task automatic t_main();
    @(negedge clk); main_clk_lost = 1'b1; pulse_gap();
    expect_word("R4 main lost unused ignored", 16'h0000);
    sys2_src = 2'b10;
    @(negedge clk); main_clk_lost = 1'b1; pulse_gap();
    expect_word("R4 main lost with PLL selected", B_MCS); clear_all();
    sys2_src = 2'b01;
  endtask

  task automatic t_sub();
    @(negedge clk); sub_clk_lost = 1'b1; pulse_gap();
    expect_word("R5 sub lost unused ignored", 16'h0000);
    sys1_src = 2'b11;
    @(negedge clk); sub_clk_lost = 1'b1; pulse_gap();
    expect_word("R5 sub lost with sub selected", B_SCS); clear_all();
    sys1_src = 2'b01;
  endtask

  task automatic t_rc_off();
    wdt_src = 2'b00;
    @(negedge clk); clk_en_off = 3'b001; pulse_gap();
    expect_word("R6 RC off without csd ignored", 16'h0000);
    csd_rst_en = 1'b1;
    @(negedge clk); clk_en_off = 3'b001; pulse_gap();
    expect_word("R6 RC off with csd", B_MCS | B_SCS); clear_all();
    csd_rst_en = 1'b0; wdt_src = 2'b01;
  endtask

  task automatic t_sw();
    @(negedge clk); sw_rst_wr = 1'b1; pulse_gap();
    expect_word("R7 software request", B_SW); clear_all();
  endtask

  task automatic t_wdt();
    @(negedge clk); wdt_expired = 1'b1; pulse_gap();
    expect_word("R8 timeout", B_WDT); clear_all();
    @(negedge clk); wdt_bad_key = 1'b1; pulse_gap();
    expect_word("R8 bad key", B_WDT); clear_all();
    wdt_src = 2'b11;
    @(negedge clk); clk_en_off = 3'b100; pulse_gap();
    expect_word("R8 source enable off", B_WDT); clear_all();
    wdt_src = 2'b00;
    @(negedge clk); rc_freq_wr = 1'b1; pulse_gap();
    expect_word("R8 RC change with main source ignored", 16'h0000);
    wdt_src = 2'b01;
    @(negedge clk); rc_freq_wr = 1'b1; pulse_gap();
    expect_word("R8 RC change with RC source", B_WDT); clear_all();
    @(negedge clk); stop_req = 1'b1; pulse_gap();
    expect_word("R8 stop without reset-on-stop ignored", 16'h0000);
    rst_on_stop = 1'b1;
    @(negedge clk); stop_req = 1'b1; pulse_gap();
    expect_word("R8 stop with reset-on-stop", B_WDT); clear_all();
    rst_on_stop = 1'b0;
  endtask

  task automatic t_collide();
    logic [15:0] d;
    @(negedge clk); wdt_expired = 1'b1; pulse_gap();
    @(negedge clk); bus_rd = 1'b1; bus_addr = BADR; sw_rst_wr = 1'b1;
    @(posedge clk); #1; d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; sw_rst_wr = 1'b0;
    check("R10 clearing read returns old flags", d, 16'h0020);
    expect_word("R10 set wins over clear", B_SW);
  endtask

  task automatic t_power_keep();
    @(negedge clk); lvd_evt = 1'b1;
    @(negedge clk); lvd_evt = 1'b0;
    expect_word("R2 LVD disabled ignored", B_SW);
    @(negedge clk); lvd_evt = 1'b1; lvd_en = 1'b1;
    @(negedge clk); lvd_evt = 1'b0; lvd_en = 1'b0;
    expect_word("R2 LVD reset keeps software flag", B_PWR | B_EXT | B_SW);
    clear_all();
  endtask

  task automatic t_pulse();
    int hi = 0;
    repeat (20) @(negedge clk);
    check("R11 idle before trigger", {15'd0, sys_rst_req}, 16'd0);
    @(negedge clk); sw_rst_wr = 1'b1;
    @(negedge clk); sw_rst_wr = 1'b0;
    check("R11 request raised", {15'd0, sys_rst_req}, 16'd1);
    if (sys_rst_req) hi++;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (sys_rst_req) hi++;
    end
    check("R11 request length", 16'(hi), 16'd16);
    clear_all();
  endtask

  initial begin
    t_reset();
    t_ext();
    t_main();
    t_sub();
    t_rc_off();
    t_sw();
    t_wdt();
    t_collide();
    t_power_keep();
    t_pulse();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule